// File: doc/BRIEF.md
# Byte-lane write-decode memory with sleep

This block is a small synchronous word memory that sits behind an address sequencer. On each rising clock edge it samples an access request: an address, a valid flag (low means the device is deselected), a global write strobe, a lane-write master enable and one write enable per byte lane. From these it decides whether the cycle is a read or a write. On a write it stores the selected lanes of the write-data word.

Reads are flow-through. The word at the sampled address is presented in the clock period that follows the sampling edge, with no further register stage. An asynchronous active-low output enable can release the data pads at any time. The pads are also released during write cycles, deselected cycles and sleep.

A sleep input freezes the block while keeping its contents. When sleep is released, one more full clock edge passes before accesses are taken again. Lane count (two or four) and lane width (8, or 9 with a parity bit) are parameters.

Top module: `lane_sram`

## Requirements
- R1: With `all_wr_n_i` low on an accepted, valid edge, every lane of the addressed word is written with `wdata_i`, whatever `lane_wr_master_n_i` and `lane_wr_n_i` hold.
- R2: With `all_wr_n_i` high and `lane_wr_master_n_i` low, exactly the lanes n whose `lane_wr_n_i[n]` is low are written. Lane n is the bit slice `[n*LANE_W +: LANE_W]` of the word.
- R3: A cycle is a read, and writes nothing, when `all_wr_n_i` and `lane_wr_master_n_i` are both high, or when the master is low but every bit of `lane_wr_n_i` is high.
- R4: A read accepted at edge k drives `dq_o` with the stored word from just after edge k until edge k+1. A word written at edge k is returned by a read accepted at edge k+1.
- R5: `oe_n_i` high forces `dq_drive_o` low and `dq_o` to zero at once, without waiting for a clock edge. Lowering it again restores the pending read data.
- R6: After a write edge or a deselected edge (`acc_valid_i` low), `dq_drive_o` is low and `dq_o` is zero. A deselected edge writes nothing, even with `all_wr_n_i` low.
- R7: While `sleep_i` is high, no write takes effect, all access inputs are ignored, `dq_drive_o` is low at once, and stored data is preserved.
- R8: The first rising edge after `sleep_i` falls is still ignored. Accesses are accepted from the edge after that.
- R9: After reset, `dq_drive_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| sleep_i | input | 1 | High requests the retained power-down state |
| acc_valid_i | input | 1 | High when an access is presented; low means deselected |
| addr_i | input | ADDR_W | Word address |
| all_wr_n_i | input | 1 | Active-low global write of all lanes |
| lane_wr_master_n_i | input | 1 | Active-low master enable for per-lane writes |
| lane_wr_n_i | input | LANES | Active-low per-lane write enables |
| wdata_i | input | LANES*LANE_W | Write data |
| oe_n_i | input | 1 | Asynchronous active-low output enable |
| dq_o | output | LANES*LANE_W | Read data; zero while not driven |
| dq_drive_o | output | 1 | High when the pads drive `dq_o`; low means high impedance |

## Verification
Write and read decode results fall due one edge after the inputs are presented. The bench drives every access on a falling edge and lets one rising edge pass. It then checks the drive flag and data on the next falling edge, which is the period the flow-through result occupies. Output-enable and sleep effects are combinational, so they are checked one nanosecond after the input changes, with no edge in between. The wake-up rule is checked by presenting a write on the first edge after sleep falls and reading the address back afterwards to confirm the old data is still there.

// File: rtl/lane_sram_pkg.sv
package lane_sram_pkg;

   typedef enum logic {
      CYC_READ  = 1'b0,
      CYC_WRITE = 1'b1
   } cyc_kind_e;

   // Active-low strobes: any global write, or master with at least one lane.
   function automatic cyc_kind_e classify(input logic gw_n, input logic master_n,
                                          input logic any_lane_low);
      if (!gw_n || (!master_n && any_lane_low)) return CYC_WRITE;
      return CYC_READ;
   endfunction

endpackage

// File: rtl/lane_sram_wdec.sv
module lane_sram_wdec
   import lane_sram_pkg::*;
#(
   parameter int LANES = 4
) (
   input  logic             go_i,
   input  logic             gw_n_i,
   input  logic             master_n_i,
   input  logic [LANES-1:0] lane_n_i,
   output logic [LANES-1:0] lane_we_o,
   output logic             is_wr_o
);

   cyc_kind_e kind;

   always_comb begin
      kind    = classify(gw_n_i, master_n_i, ~&lane_n_i);
      is_wr_o = (kind == CYC_WRITE);
   end

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         always_comb begin
            if (!go_i)            lane_we_o[g] = 1'b0;
            else if (!gw_n_i)     lane_we_o[g] = 1'b1;
            else if (!master_n_i) lane_we_o[g] = ~lane_n_i[g];
            else                  lane_we_o[g] = 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/lane_sram_lane.sv
module lane_sram_lane #(
   parameter int DEPTH  = 64,
   parameter int LANE_W = 9,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we_i,
   input  logic [AW-1:0]     waddr_i,
   input  logic [LANE_W-1:0] wd_i,
   input  logic [AW-1:0]     raddr_i,
   output logic [LANE_W-1:0] rd_o
);

   logic [LANE_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we_i) mem[waddr_i] <= wd_i;
   end

   assign rd_o = mem[raddr_i];

endmodule

// File: rtl/lane_sram_ctrl.sv
module lane_sram_ctrl #(
   parameter int AW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sleep_i,
   input  logic          valid_i,
   input  logic          is_wr_i,
   input  logic [AW-1:0] addr_i,
   input  logic          oe_n_i,
   output logic          go_o,
   output logic [AW-1:0] raddr_o,
   output logic          drive_o
);

   logic slp_q;
   logic rd_q;

   // Accept only when sleep is low now and was low at the previous edge.
   assign go_o = !sleep_i && !slp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slp_q   <= 1'b0;
         rd_q    <= 1'b0;
         raddr_o <= '0;
      end else begin
         slp_q <= sleep_i;
         rd_q  <= go_o && valid_i && !is_wr_i;
         if (go_o && valid_i && !is_wr_i) raddr_o <= addr_i;
      end
   end

   assign drive_o = rd_q && !oe_n_i && !sleep_i;

   assert_wake_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sleep_i) |-> !go_o);

endmodule

// File: rtl/lane_sram.sv
module lane_sram #(
   parameter int LANES  = 4,
   parameter int LANE_W = 9,
   parameter int DEPTH  = 64,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int DATA_W = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sleep_i,
   input  logic              acc_valid_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              all_wr_n_i,
   input  logic              lane_wr_master_n_i,
   input  logic [LANES-1:0]  lane_wr_n_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              oe_n_i,
   output logic [DATA_W-1:0] dq_o,
   output logic              dq_drive_o
);

   initial begin
      assert (LANES == 2 || LANES == 4) else $error("LANES must be 2 or 4");
      assert (LANE_W == 8 || LANE_W == 9) else $error("LANE_W must be 8 or 9");
      assert (DEPTH == (1 << ADDR_W)) else $error("DEPTH must be a power of two");
   end

   logic              go;
   logic              is_wr;
   logic [LANES-1:0]  lane_we;
   logic [ADDR_W-1:0] raddr;
   logic [DATA_W-1:0] rword;

   lane_sram_ctrl #(.AW(ADDR_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .sleep_i (sleep_i),
      .valid_i (acc_valid_i),
      .is_wr_i (is_wr),
      .addr_i  (addr_i),
      .oe_n_i  (oe_n_i),
      .go_o    (go),
      .raddr_o (raddr),
      .drive_o (dq_drive_o)
   );

   lane_sram_wdec #(.LANES(LANES)) u_wdec (
      .go_i       (go && acc_valid_i),
      .gw_n_i     (all_wr_n_i),
      .master_n_i (lane_wr_master_n_i),
      .lane_n_i   (lane_wr_n_i),
      .lane_we_o  (lane_we),
      .is_wr_o    (is_wr)
   );

   generate
      for (genvar n = 0; n < LANES; n++) begin : g_lane
         lane_sram_lane #(.DEPTH(DEPTH), .LANE_W(LANE_W)) u_lane (
            .clk     (clk),
            .we_i    (lane_we[n]),
            .waddr_i (addr_i),
            .wd_i    (wdata_i[n*LANE_W +: LANE_W]),
            .raddr_i (raddr),
            .rd_o    (rword[n*LANE_W +: LANE_W])
         );
      end
   endgenerate

   assign dq_o = dq_drive_o ? rword : '0;

   assert_all_lanes_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid_i && !sleep_i && !$past(sleep_i) && !all_wr_n_i) |-> (&lane_we));

   assert_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (all_wr_n_i && !lane_wr_master_n_i) |-> ((lane_we & lane_wr_n_i) == '0));

   assert_read_nowrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (all_wr_n_i && (lane_wr_master_n_i || (&lane_wr_n_i))) |-> (lane_we == '0));

   assert_drive_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
      dq_drive_o |-> $past(acc_valid_i && all_wr_n_i && !sleep_i));

   assert_oe_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n_i |-> !dq_drive_o);

   assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !dq_drive_o |-> (dq_o == '0));

   assert_sleep_nowrite_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sleep_i |-> (lane_we == '0 && !dq_drive_o));

   assert_wake_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sleep_i) |-> (lane_we == '0));

endmodule

// File: tb/lane_sram_tb.sv
`timescale 1ns/1ps
module lane_sram_tb;

   localparam int LANES = 4;
   localparam int LW    = 9;
   localparam int DEPTH = 64;
   localparam int AW    = 6;
   localparam int DW    = LANES * LW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sleep_i = 1'b0;
   logic          acc_valid_i = 1'b0;
   logic [AW-1:0] addr_i = '0;
   logic          all_wr_n_i = 1'b1;
   logic          lane_wr_master_n_i = 1'b1;
   logic [LANES-1:0] lane_wr_n_i = '1;
   logic [DW-1:0] wdata_i = '0;
   logic          oe_n_i = 1'b0;
   logic [DW-1:0] dq_o;
   logic          dq_drive_o;

   int checks = 0;
   int errors = 0;
   logic [DW-1:0] model [DEPTH];

   always #2.5 clk = ~clk;

   lane_sram #(.LANES(LANES), .LANE_W(LW), .DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i), .acc_valid_i(acc_valid_i),
      .addr_i(addr_i), .all_wr_n_i(all_wr_n_i), .lane_wr_master_n_i(lane_wr_master_n_i),
      .lane_wr_n_i(lane_wr_n_i), .wdata_i(wdata_i), .oe_n_i(oe_n_i),
      .dq_o(dq_o), .dq_drive_o(dq_drive_o)
   );

   function automatic logic [DW-1:0] pat(input int a, input int k);
      logic [63:0] v;
      v = (64'(a) * 64'd2654435761) ^ (64'(k) * 64'd40503) ^ 64'h5A5A_1234_9;
      return v[DW-1:0];
   endfunction

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Called at a falling edge; returns at the next falling edge.
   task automatic cyc(input logic v, input int a, input logic gw_n, input logic m_n,
                      input logic [LANES-1:0] be_n, input logic [DW-1:0] wd);
      acc_valid_i = v; addr_i = AW'(a); all_wr_n_i = gw_n;
      lane_wr_master_n_i = m_n; lane_wr_n_i = be_n; wdata_i = wd;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic rd(input string req, input int a, input logic alt);
      // alt selects the second read encoding: master low, all lanes high
      if (alt) cyc(1'b1, a, 1'b1, 1'b0, '1, ~pat(a, 99));
      else     cyc(1'b1, a, 1'b1, 1'b1, 4'b0000, ~pat(a, 98));
      chk({req, " drive"}, DW'(dq_drive_o), DW'(1));
      chk({req, " data"}, dq_o, model[a]);
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [DW-1:0] wd;
      logic [LANES-1:0] m;
      repeat (3) @(negedge clk);
      chk("R9 reset drive", DW'(dq_drive_o), '0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: global write ignores master and lane enables
      for (int a = 0; a < DEPTH; a++) begin
         wd = pat(a, 1);
         cyc(1'b1, a, 1'b0, a[0], LANES'(a), wd);
         model[a] = wd;
         chk("R6 write releases pads", {dq_o[DW-2:0], dq_drive_o}, '0);
      end
      // R3/R4: read back with both read encodings
      for (int a = 0; a < DEPTH; a++) rd("R1 R3 R4 readback", a, a[0]);

      // R2: every lane mask, including all-high (a read per R3)
      for (int a = 0; a < DEPTH; a++) begin
         m  = LANES'(a);
         wd = pat(a, 7);
         cyc(1'b1, a, 1'b1, 1'b0, m, wd);
         if (m != '1) chk("R6 masked write releases pads", DW'(dq_drive_o), '0);
         for (int l = 0; l < LANES; l++)
            if (!m[l]) model[a][l*LW +: LW] = wd[l*LW +: LW];
         rd("R2 lane mask", a, 1'b0);
      end

      // R6: deselected edge with global write low writes nothing
      cyc(1'b0, 5, 1'b0, 1'b0, '0, pat(5, 55));
      chk("R6 deselect drive", DW'(dq_drive_o), '0);
      rd("R6 deselect no write", 5, 1'b0);

      // R5: asynchronous output enable
      oe_n_i = 1'b1; #1;
      chk("R5 oe high drive", DW'(dq_drive_o), '0);
      chk("R5 oe high data", dq_o, '0);
      oe_n_i = 1'b0; #1;
      chk("R5 oe low restores", dq_o, model[5]);
      @(negedge clk);

      // R7: sleep releases pads at once and blocks writes
      rd("R7 pre-sleep read", 9, 1'b0);
      sleep_i = 1'b1; #1;
      chk("R7 sleep drive", DW'(dq_drive_o), '0);
      @(negedge clk);
      cyc(1'b1, 9, 1'b0, 1'b0, '0, pat(9, 66));
      cyc(1'b1, 9, 1'b1, 1'b1, '1, '0);
      chk("R7 sleep read ignored", DW'(dq_drive_o), '0);
      // R8: first edge after wake is ignored
      sleep_i = 1'b0;
      cyc(1'b1, 9, 1'b0, 1'b1, '1, pat(9, 77));
      chk("R8 wake edge no drive", DW'(dq_drive_o), '0);
      rd("R7 R8 contents kept", 9, 1'b0);
      wd = pat(9, 88);
      cyc(1'b1, 9, 1'b0, 1'b1, '1, wd);
      model[9] = wd;
      rd("R8 accepted after wake", 9, 1'b1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule